// File: doc/BRIEF.md
# Compressed-to-Base Instruction Recoder

This block is the front half of a serial instruction decoder. Each cycle it may take one instruction word along with a length tag and a mode bit. It turns the supported 16-bit compressed forms into equivalent standard 32-bit base instructions. An unchanged base decoder placed after it then handles the result. In base mode, and for words tagged as 32-bit, the word goes through unchanged. The recoder widens the short register codes to full 5-bit register numbers, scales the short offsets into byte offsets, and fills in implied base registers.

The block handles three compressed forms. The first is a word load with an explicit base and offset. The second is a word load relative to the stack pointer. The third is a return that also adjusts the stack pointer. The return form becomes two base instructions on consecutive cycles: a jump-register through register 31, then an add-immediate on register 29. While the first of the two is on the output, `stall` is high, and any input offered during that cycle is not taken. An unknown compressed opcode raises a reserved-instruction flag and produces an all-zero no-op. Every result appears on the output one clock after the input is accepted.

Top module: `cbrecode`

## Requirements
- R1: When `modeCompact` is 0, an accepted word appears unchanged on `outWord` one cycle later, with `outValid` high and `rsvdFlag` low, whatever the value of `inShort`.
- R2: When `modeCompact` is 1 and `inShort` is 0, the word also passes unchanged, one cycle later.
- R3: A compressed word has its major opcode in bits [15:10], and bits [31:16] are ignored. Major 6'b011010 is the short load: target code in [9:7], base code in [6:4], offset in [3:0]. It becomes the base load `{6'h23, base[4:0], target[4:0], imm16}`.
- R4: A 3-bit register code c maps to register 16 when c=0 and to register 17 when c=1. Every other code c maps to register c (registers 2 to 7).
- R5: The short-load offset is shifted left by two and zero-extended into imm16, so the byte offsets run from 0 to 60.
- R6: Major 6'b010010 is the stack-pointer load: target in [9:5], offset in [4:0]. It becomes `{6'h23, 5'd29, target, imm16}`, where imm16 is the offset shifted left by two and zero-extended.
- R7: Major 6'b010001 with minor bits [9:7]=3'b101 is the return with stack adjust, carrying a 7-bit immediate in [6:0]. It produces 32'h03E00008 with `stall` high, and on the next cycle 32'h27BD0000 plus the immediate times four, with `stall` low.
- R8: While `stall` is high, the input is not accepted. The word offered in that cycle produces no output of its own until it is offered again after the stall.
- R9: In compact mode, a short word with any other major opcode, or with major 6'b010001 and a minor other than 3'b101, gives `outValid` high, `rsvdFlag` high and `outWord` equal to 0.
- R10: In a cycle that follows one with no accepted input and no pending second half, `outValid` is low.
- R11: After reset, `outValid`, `stall` and `rsvdFlag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Input word offered this cycle |
| inWord | input | 32 | Instruction word; compressed forms use bits [15:0] |
| inShort | input | 1 | Length tag: 1 marks a 16-bit instruction |
| modeCompact | input | 1 | 1 selects the compressed ISA; 0 selects base mode |
| outValid | output | 1 | A base instruction is present on `outWord` |
| outWord | output | 32 | Recoded base instruction |
| stall | output | 1 | First half of a two-part expansion; input not accepted |
| rsvdFlag | output | 1 | Reserved or unknown compressed instruction |

## Verification
Base-mode words are sent with the length tag both set and clear. If the recoder leaked into base mode, the tagged case would show it. Short loads are sent across all eight register codes and at the smallest and largest offsets, which catches a wrong mapping table, a swapped field or a missing shift. The return form is sent with immediates of 0 and 127. A load follows straight after it, so a stall that fails to hold off input, or an order of the two halves that is swapped, shows up as an extra or misplaced item in the scoreboard. Reserved cases use an unused major opcode and the right major opcode with a wrong minor.

// File: rtl/cbrecode_pkg.sv
package cbrecode_pkg;
  localparam int WORD_W   = 32;
  localparam int HALF_W   = WORD_W / 2;
  localparam int OPC_W    = 6;
  localparam int REG_W    = 5;
  localparam int CODE_W   = 3;

  // compressed major opcodes and the one recognised minor
  localparam logic [OPC_W-1:0]  MAJ_LDW  = 6'b011010;
  localparam logic [OPC_W-1:0]  MAJ_LDSP = 6'b010010;
  localparam logic [OPC_W-1:0]  MAJ_RET  = 6'b010001;
  localparam logic [CODE_W-1:0] MIN_RET  = 3'b101;

  // base encodings
  localparam logic [OPC_W-1:0] OP_LW    = 6'h23;
  localparam logic [OPC_W-1:0] OP_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OP_SPEC  = 6'h00;
  localparam logic [OPC_W-1:0] FN_JR    = 6'h08;
  localparam logic [REG_W-1:0] REG_SP   = 5'd29;
  localparam logic [REG_W-1:0] REG_RA   = 5'd31;

  typedef enum logic [2:0] {
    SEL_PASS, SEL_LDW, SEL_LDSP, SEL_JMP, SEL_ADJ, SEL_NOP
  } selE;

  typedef struct packed {
    logic load;
    selE  sel;
    logic rsvd;
  } strobeT;

  function automatic logic [REG_W-1:0] expandReg(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 5'd16;
      3'd1:    return 5'd17;
      default: return {2'b00, code};
    endcase
  endfunction
endpackage

// File: rtl/cbrecode_ctrl.sv
module cbrecode_ctrl
  import cbrecode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              shortMode,
  input  logic [OPC_W-1:0]  major,
  input  logic [CODE_W-1:0] minor,
  output strobeT            strb,
  output logic              pending
);
  always_comb begin
    strb.load = 1'b0;
    strb.sel  = SEL_PASS;
    strb.rsvd = 1'b0;
    if (pending) begin
      strb.load = 1'b1;
      strb.sel  = SEL_ADJ;
    end else if (inValid) begin
      strb.load = 1'b1;
      if (shortMode) begin
        case (major)
          MAJ_LDW:  strb.sel = SEL_LDW;
          MAJ_LDSP: strb.sel = SEL_LDSP;
          MAJ_RET: begin
            if (minor == MIN_RET) begin
              strb.sel = SEL_JMP;
            end else begin
              strb.sel  = SEL_NOP;
              strb.rsvd = 1'b1;
            end
          end
          default: begin
            strb.sel  = SEL_NOP;
            strb.rsvd = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= strb.load && (strb.sel == SEL_JMP);
  end
endmodule

// File: rtl/cbrecode_dp.sv
module cbrecode_dp
  import cbrecode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [WORD_W-1:0] inWord,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid,
  output logic              rsvdFlag
);
  localparam int ADJ_W = 7;

  logic [ADJ_W-1:0]  savedImm;
  logic [WORD_W-1:0] nextWord;

  always_comb begin
    case (strb.sel)
      SEL_PASS: nextWord = inWord;
      SEL_LDW:  nextWord = {OP_LW, expandReg(inWord[6:4]), expandReg(inWord[9:7]),
                            10'b0, inWord[3:0], 2'b00};
      SEL_LDSP: nextWord = {OP_LW, REG_SP, inWord[9:5], 9'b0, inWord[4:0], 2'b00};
      SEL_JMP:  nextWord = {OP_SPEC, REG_RA, 15'b0, FN_JR};
      SEL_ADJ:  nextWord = {OP_ADDIU, REG_SP, REG_SP, 7'b0, savedImm, 2'b00};
      default:  nextWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWord  <= '0;
      outValid <= 1'b0;
      rsvdFlag <= 1'b0;
      savedImm <= '0;
    end else begin
      outValid <= strb.load;
      rsvdFlag <= strb.load && strb.rsvd;
      if (strb.load) outWord <= nextWord;
      if (strb.load && strb.sel == SEL_JMP) savedImm <= inWord[ADJ_W-1:0];
    end
  end
endmodule

// File: rtl/cbrecode.sv
module cbrecode
  import cbrecode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inShort,
  input  logic              modeCompact,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord,
  output logic              stall,
  output logic              rsvdFlag
);
  strobeT strb;

  cbrecode_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .shortMode(modeCompact && inShort),
    .major    (inWord[HALF_W-1 -: OPC_W]),
    .minor    (inWord[9:7]),
    .strb     (strb),
    .pending  (stall)
  );

  cbrecode_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inWord  (inWord),
    .outWord (outWord),
    .outValid(outValid),
    .rsvdFlag(rsvdFlag)
  );
endmodule

// File: rtl/cbrecode_chk.sv
module cbrecode_chk
  import cbrecode_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [WORD_W-1:0] inWord,
  input logic              inShort,
  input logic              modeCompact,
  input logic              outValid,
  input logic [WORD_W-1:0] outWord,
  input logic              stall,
  input logic              rsvdFlag
);
  // R1
  base_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !stall && !modeCompact) |=> (outValid && !rsvdFlag && outWord == $past(inWord)));

  // R7
  stall_jump_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (outValid && outWord == 32'h03E00008));

  // R7
  adjust_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (!stall && outValid && outWord[31:16] == 16'h27BD));

  // R9
  rsvd_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    rsvdFlag |-> (outValid && outWord == '0 && !stall));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !stall) |=> !outValid);
endmodule

bind cbrecode cbrecode_chk u_chk (.*);

// File: tb/cbrecode_tb.sv
module cbrecode_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        inShort = 1'b0;
  logic        modeCompact = 1'b0;
  logic        outValid;
  logic [31:0] outWord;
  logic        stall;
  logic        rsvdFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] expWordQ[$];
  logic        expRsvdQ[$];
  logic        expStallQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  cbrecode u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .inShort(inShort), .modeCompact(modeCompact), .outValid(outValid),
    .outWord(outWord), .stall(stall), .rsvdFlag(rsvdFlag)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int regMap(input logic [2:0] c);
    if (c == 3'd0) return 16;
    if (c == 3'd1) return 17;
    return int'(c);
  endfunction

  task automatic push(input logic [31:0] w, input logic r, input logic s, input string tag);
    expWordQ.push_back(w);
    expRsvdQ.push_back(r);
    expStallQ.push_back(s);
    tagQ.push_back(tag);
  endtask

  task automatic send(input logic [31:0] w, input logic sh, input logic md, input string tag);
    int rs, rt, off;
    @(negedge clk);
    while (stall) @(negedge clk);
    inValid = 1'b1; inWord = w; inShort = sh; modeCompact = md;
    if (!md || !sh) push(w, 1'b0, 1'b0, tag);
    else if (w[15:10] == 6'b011010) begin
      rt = regMap(w[9:7]); rs = regMap(w[6:4]); off = int'(w[3:0]) * 4;
      push(32'h8C000000 | (rs << 21) | (rt << 16) | off, 1'b0, 1'b0, tag);
    end else if (w[15:10] == 6'b010010) begin
      rt = int'(w[9:5]); off = int'(w[4:0]) * 4;
      push(32'h8C000000 | (29 << 21) | (rt << 16) | off, 1'b0, 1'b0, tag);
    end else if (w[15:10] == 6'b010001 && w[9:7] == 3'b101) begin
      push(32'h03E00008, 1'b0, 1'b1, tag);
      push(32'h27BD0000 | (int'(w[6:0]) * 4), 1'b0, 1'b0, tag);
    end else push(32'h0, 1'b1, 1'b0, tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    while (stall) @(negedge clk);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !done && outValid) begin
      if (expWordQ.size() == 0) begin
        check(1'b0, "R10 unexpected output", outWord, 32'h0);
      end else begin
        logic [31:0] ew; logic er, es; string t;
        ew = expWordQ.pop_front(); er = expRsvdQ.pop_front();
        es = expStallQ.pop_front(); t = tagQ.pop_front();
        check(outWord == ew, {t, " word"}, outWord, ew);
        check(rsvdFlag == er, {t, " rsvd"}, 32'(rsvdFlag), 32'(er));
        check(stall == es, {t, " stall"}, 32'(stall), 32'(es));
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!outValid && !stall && !rsvdFlag, "R11 reset", {29'b0, outValid, stall, rsvdFlag}, 32'h0);

    // R1 base mode, tag clear and set
    send(32'h12345678, 1'b0, 1'b0, "R1 base");
    send(32'h0000682F, 1'b1, 1'b0, "R1 base tagged");
    send(32'h44D7FFFF, 1'b1, 1'b0, "R1 base tagged2");
    // R2 compact mode 32-bit word
    send(32'h0000682F, 1'b0, 1'b1, "R2 long");
    // R3 R4 all register codes, R5 offsets
    for (int c = 0; c < 8; c++) begin
      send({16'hA5A5, 6'b011010, 3'(c), 3'(7 - c), 4'(c * 2)}, 1'b1, 1'b1, "R3 R4 load");
    end
    send({16'hFFFF, 6'b011010, 3'd3, 3'd0, 4'h0}, 1'b1, 1'b1, "R5 offset min");
    send({16'h0000, 6'b011010, 3'd1, 3'd6, 4'hF}, 1'b1, 1'b1, "R5 offset max");
    // R6 stack loads
    send({16'h5A5A, 6'b010010, 5'd0, 5'd0}, 1'b1, 1'b1, "R6 sp min");
    send({16'h0000, 6'b010010, 5'd31, 5'd31}, 1'b1, 1'b1, "R6 sp max");
    send({16'h0000, 6'b010010, 5'd9, 5'd17}, 1'b1, 1'b1, "R6 sp mid");
    // R7 return, R8 next word offered during stall
    send({16'h0000, 6'b010001, 3'b101, 7'd0}, 1'b1, 1'b1, "R7 ret imm0");
    send({16'h0000, 6'b011010, 3'd2, 3'd5, 4'h9}, 1'b1, 1'b1, "R8 after stall");
    send({16'hC3C3, 6'b010001, 3'b101, 7'd127}, 1'b1, 1'b1, "R7 ret imm127");
    send(32'hDEADBEEF, 1'b0, 1'b0, "R8 base after stall");
    // R9 reserved
    send({16'h0000, 6'b111111, 10'h155}, 1'b1, 1'b1, "R9 unknown major");
    send({16'h0000, 6'b010001, 3'b000, 7'd5}, 1'b1, 1'b1, "R9 bad minor");
    send({16'h0000, 6'b011010, 3'd4, 3'd4, 4'h4}, 1'b1, 1'b1, "R9 recovery");
    // R10 idle
    idle(3);
    check(!outValid, "R10 idle", 32'(outValid), 32'h0);
    check(expWordQ.size() == 0, "R8 drain", 32'(expWordQ.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule